// File: doc/BRIEF.md
# Two-Wire Register Slave with Layered Write Protection

This block is the serial-bus front end of a small configuration device. It listens on a two-wire bus (SCL and an open-drain SDA), answers to one 7-bit device address, and gives the host byte-level access to a 256-entry address space. Configuration bytes live at 0x00 to 0x45 and a 128-byte scratch memory lives at 0x80 to 0xFF. All other addresses read as zero and ignore writes. The 7-bit address is made of a 4-bit device type that software can change, followed by three strap pins. Storage is modelled as a register array inside the block.

A write transaction has three parts: the device address, a pointer byte, and then one or more data bytes. Further data bytes advance only the low four pointer bits, so a burst stays inside its 16-byte page. To read, the host first sets the pointer with a write that has no STOP, then sends a repeated START with the read address. It clocks bytes out, acknowledging each one, and the pointer runs across the whole space. The read ends when the host NACKs and sends STOP.

Writes are filtered by four separate things. The first is a volatile protection register with separate nibble unlock codes for memory and for configuration. The second is an active-low protect pin. The third is a sticky lock bit that freezes configuration. The fourth is the address decode itself. A blocked write is still acknowledged so the host protocol never stalls.

Top module: `i2cs_regslave`

## Requirements
- R1: The slave acknowledges an address byte only when bits [7:4] equal the device type held in register 0x43 bits [3:0] (0xA after reset) and bits [3:1] equal `pin_addr_i`. On a mismatch it sends no ACK and keeps SDA released until the next START.
- R2: Every accepted address, pointer or write-data byte is acknowledged by pulling SDA low during the ninth SCL high phase. Data is sampled on SCL rising edges, MSB first.
- R3: In a write, the byte after the address is the pointer and each later byte is stored at the pointer. The pointer then advances in bits [3:0] only, wrapping inside its 16-byte page.
- R4: After a pointer-setting write and a repeated START with the read bit (bit 0 = 1), data is driven MSB first on SCL falling edges from the pointer. The pointer advances through the full 8-bit space (0xFF to 0x00) while the host ACKs.
- R5: When the host NACKs a read byte, the slave leaves SDA released until the next START.
- R6: The protection register at 0x42 is write-only, reads as 0x00, and is 0x00 after reset, which locks both regions.
- R7: A value of 0101 in protection bits [7:4] opens memory (0x80–0xFF) to writes. A value of 0101 in bits [3:0] opens configuration (0x00–0x45 except 0x42). Any other nibble value closes that region again.
- R8: While `wp_n_i` is low, no configuration or memory byte changes.
- R9: Once register 0x43 bit 7 (lock) is set, no configuration byte changes, including 0x43 itself, until reset.
- R10: A write that is blocked is still acknowledged and leaves storage unchanged.
- R11: After reset SDA is released. A STOP returns to idle with SDA released. A START at any point, including mid-byte, restarts the address phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | High pulls SDA low (open drain) |
| pin_addr_i | input | 3 | Strapped low address bits |
| wp_n_i | input | 1 | Active-low write protect pin |

## Verification
The assertions assume bus edges are far enough apart that each one is seen in a separate system clock cycle after synchronisation. They also assume SDA never changes in the same cycle as an SCL edge, so START and STOP are never confused with data bits. The stimulus holds every bus phase for eight system clocks and changes SDA only in the middle of SCL low, except when it deliberately forms a START or STOP. The protect pin and strap pins change only between transactions.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    localparam logic [7:0] PROT_ADDR   = 8'h42;
    localparam logic [7:0] CTL_ADDR    = 8'h43;
    localparam logic [3:0] UNLOCK_CODE = 4'h5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_PTR,
        ST_WR,
        ST_RD,
        ST_RACK
    } bus_state_e;

    typedef struct packed {
        logic       we;
        logic [7:0] addr;
        logic [7:0] data;
    } store_req_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } line_ev_t;

    // advance the low pb bits of a pointer, keep the page bits
    function automatic logic [7:0] page_next(input logic [7:0] a, input int pb);
        logic [7:0] m;
        m = 8'((1 << pb) - 1);
        return (a & ~m) | (8'(a + 8'd1) & m);
    endfunction

endpackage

// File: rtl/i2cs_line_sync.sv
module i2cs_line_sync
    import i2cs_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output line_ev_t ev_o
);

    logic [1:0] raw;
    logic [1:0] synced;
    logic [1:0] last_q;

    assign raw = {scl_i, sda_i};

    genvar g;
    generate
        for (g = 0; g < 2; g++) begin : g_line
            logic [STAGES-1:0] chain_q;
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '1;
                else     chain_q <= {chain_q[STAGES-2:0], raw[g]};
            end
            assign synced[g] = chain_q[STAGES-1];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last_q <= '1;
        else     last_q <= synced;
    end

    always_comb begin
        ev_o.scl_rise = synced[1] & ~last_q[1];
        ev_o.scl_fall = ~synced[1] & last_q[1];
        ev_o.start    = synced[1] & last_q[1] & ~synced[0] & last_q[0];
        ev_o.stop     = synced[1] & last_q[1] & synced[0] & ~last_q[0];
        ev_o.sda      = synced[0];
    end

endmodule

// File: rtl/i2cs_store.sv
module i2cs_store
    import i2cs_pkg::*;
#(
    parameter int         CFG_N        = 70,
    parameter int         MEM_N        = 128,
    parameter logic [3:0] DEV_TYPE_RST = 4'hA
) (
    input  logic       clk,
    input  logic       rst,
    input  store_req_t req_i,
    input  logic       wp_n_i,
    input  logic [7:0] raddr_i,
    output logic [7:0] rdata_o,
    output logic [3:0] dev_type_o
);

    localparam int              CFG_AW   = $clog2(CFG_N);
    localparam int              MEM_AW   = $clog2(MEM_N);
    localparam logic [7:0]      CFG_END  = 8'(CFG_N);
    localparam logic [7:0]      MEM_BASE = 8'(256 - MEM_N);
    localparam logic [CFG_AW-1:0] CTL_IDX = CTL_ADDR[CFG_AW-1:0];

    logic [CFG_N-1:0][7:0] cfg_q;
    logic [MEM_N-1:0][7:0] mem_q;
    logic [7:0]            prot_q;
    logic                  lock;
    logic                  cfg_open, mem_open;
    logic                  w_cfg_hit, w_mem_hit, r_cfg_hit, r_mem_hit;

    assign lock       = cfg_q[CTL_IDX][7];
    assign dev_type_o = cfg_q[CTL_IDX][3:0];

    assign cfg_open = wp_n_i && (prot_q[3:0] == UNLOCK_CODE) && !lock;
    assign mem_open = wp_n_i && (prot_q[7:4] == UNLOCK_CODE);

    assign w_cfg_hit = (req_i.addr < CFG_END) && (req_i.addr != PROT_ADDR);
    assign w_mem_hit = (req_i.addr >= MEM_BASE);
    assign r_cfg_hit = (raddr_i < CFG_END) && (raddr_i != PROT_ADDR);
    assign r_mem_hit = (raddr_i >= MEM_BASE);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q          <= '0;
            cfg_q[CTL_IDX] <= {4'h0, DEV_TYPE_RST};
            mem_q          <= '0;
            prot_q         <= '0;
        end else if (req_i.we) begin
            if (req_i.addr == PROT_ADDR)
                prot_q <= req_i.data;
            else if (w_cfg_hit && cfg_open)
                cfg_q[req_i.addr[CFG_AW-1:0]] <= req_i.data;
            else if (w_mem_hit && mem_open)
                mem_q[req_i.addr[MEM_AW-1:0]] <= req_i.data;
        end
    end

    always_comb begin
        if (r_cfg_hit)      rdata_o = cfg_q[raddr_i[CFG_AW-1:0]];
        else if (r_mem_hit) rdata_o = mem_q[raddr_i[MEM_AW-1:0]];
        else                rdata_o = 8'h00;
    end

    // R8: pin protection freezes both regions
    p_pin_freeze_r8: assert property (@(posedge clk) disable iff (rst)
        !wp_n_i |=> ($stable(cfg_q) && $stable(mem_q)));

    // R9: lock is sticky and freezes configuration
    p_lock_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        lock |=> lock);
    p_lock_freeze_r9: assert property (@(posedge clk) disable iff (rst)
        lock |=> $stable(cfg_q));

    // R7: memory closed unless its nibble holds the unlock code
    p_mem_closed_r7: assert property (@(posedge clk) disable iff (rst)
        (prot_q[7:4] != UNLOCK_CODE) |=> $stable(mem_q));

endmodule

// File: rtl/i2cs_regslave.sv
module i2cs_regslave
    import i2cs_pkg::*;
#(
    parameter logic [3:0] DEV_TYPE_RST = 4'hA,
    parameter int         CFG_N        = 70,
    parameter int         MEM_N        = 128,
    parameter int         PAGE_BITS    = 4,
    parameter int         SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o,
    input  logic [2:0] pin_addr_i,
    input  logic       wp_n_i
);

    localparam logic [3:0] BYTE_BITS = 4'd8;

    line_ev_t   ev;
    bus_state_e state_q;
    logic       in_ack_q, rw_q, host_ack_q, oe_q;
    logic [3:0] bitcnt_q;
    logic [7:0] shreg_q, tx_q, ptr_q;
    store_req_t req_q;
    logic [7:0] rdata;
    logic [3:0] dev_type;

    i2cs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev_o  (ev)
    );

    i2cs_store #(
        .CFG_N        (CFG_N),
        .MEM_N        (MEM_N),
        .DEV_TYPE_RST (DEV_TYPE_RST)
    ) u_store (
        .clk        (clk),
        .rst        (rst),
        .req_i      (req_q),
        .wp_n_i     (wp_n_i),
        .raddr_i    (ptr_q),
        .rdata_o    (rdata),
        .dev_type_o (dev_type)
    );

    assign sda_oe_o = oe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            in_ack_q   <= 1'b0;
            rw_q       <= 1'b0;
            host_ack_q <= 1'b0;
            oe_q       <= 1'b0;
            bitcnt_q   <= '0;
            shreg_q    <= '0;
            tx_q       <= '0;
            ptr_q      <= '0;
            req_q      <= '0;
        end else begin
            req_q.we <= 1'b0;
            if (ev.start) begin
                state_q  <= ST_DEV;
                bitcnt_q <= '0;
                in_ack_q <= 1'b0;
                oe_q     <= 1'b0;
            end else if (ev.stop) begin
                state_q  <= ST_IDLE;
                in_ack_q <= 1'b0;
                oe_q     <= 1'b0;
            end else begin
                case (state_q)
                    ST_DEV, ST_PTR, ST_WR: begin
                        if (ev.scl_rise && !in_ack_q && bitcnt_q != BYTE_BITS) begin
                            shreg_q  <= {shreg_q[6:0], ev.sda};
                            bitcnt_q <= bitcnt_q + 4'd1;
                        end else if (ev.scl_fall && in_ack_q) begin
                            in_ack_q <= 1'b0;
                            oe_q     <= 1'b0;
                            bitcnt_q <= '0;
                            if (state_q == ST_DEV) begin
                                if (rw_q) begin
                                    state_q <= ST_RD;
                                    tx_q    <= rdata;
                                    oe_q    <= ~rdata[7];
                                end else begin
                                    state_q <= ST_PTR;
                                end
                            end else if (state_q == ST_PTR) begin
                                state_q <= ST_WR;
                            end
                        end else if (ev.scl_fall && bitcnt_q == BYTE_BITS) begin
                            if (state_q == ST_DEV) begin
                                if (shreg_q[7:1] == {dev_type, pin_addr_i}) begin
                                    in_ack_q <= 1'b1;
                                    oe_q     <= 1'b1;
                                    rw_q     <= shreg_q[0];
                                end else begin
                                    state_q <= ST_IDLE;
                                end
                            end else if (state_q == ST_PTR) begin
                                ptr_q    <= shreg_q;
                                in_ack_q <= 1'b1;
                                oe_q     <= 1'b1;
                            end else begin
                                req_q    <= '{we: 1'b1, addr: ptr_q, data: shreg_q};
                                ptr_q    <= page_next(ptr_q, PAGE_BITS);
                                in_ack_q <= 1'b1;
                                oe_q     <= 1'b1;
                            end
                        end
                    end
                    ST_RD: begin
                        if (ev.scl_rise) begin
                            bitcnt_q <= bitcnt_q + 4'd1;
                        end else if (ev.scl_fall) begin
                            if (bitcnt_q == BYTE_BITS) begin
                                oe_q     <= 1'b0;
                                state_q  <= ST_RACK;
                                bitcnt_q <= '0;
                                ptr_q    <= ptr_q + 8'd1;
                            end else begin
                                tx_q <= {tx_q[6:0], 1'b0};
                                oe_q <= ~tx_q[6];
                            end
                        end
                    end
                    ST_RACK: begin
                        if (ev.scl_rise) begin
                            host_ack_q <= ~ev.sda;
                        end else if (ev.scl_fall) begin
                            if (host_ack_q) begin
                                state_q  <= ST_RD;
                                tx_q     <= rdata;
                                oe_q     <= ~rdata[7];
                                bitcnt_q <= '0;
                            end else begin
                                state_q <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R5 / R11: idle never pulls the line
    p_idle_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE) |-> !oe_q);

    // R2: line held low across the acknowledge clock
    p_ack_drive_r2: assert property (@(posedge clk) disable iff (rst)
        (ev.scl_rise && in_ack_q) |-> oe_q);

    // R3: pointer stays within the page of the byte just written
    p_page_hold_r3: assert property (@(posedge clk) disable iff (rst)
        req_q.we |-> (ptr_q[7:PAGE_BITS] == req_q.addr[7:PAGE_BITS]));

    // R11: a start always reopens the address phase
    p_start_restart_r11: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> (state_q == ST_DEV && !oe_q));

    // R10: storage requests only come from the write-data phase
    p_req_phase_r10: assert property (@(posedge clk) disable iff (rst)
        req_q.we |-> (state_q == ST_WR));

endmodule

// File: tb/i2cs_regslave_test.sv
module i2cs_regslave_test;

    localparam int CLK_NS = 10;
    localparam int Q      = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl = 1'b1;
    logic       sda_drv = 1'b1;
    logic       wp_n = 1'b1;
    logic [2:0] pins = 3'b101;
    logic       sda_oe;
    logic       sda_bus;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] got_q[$];
    logic [7:0] wbuf[16];

    assign sda_bus = sda_drv & ~sda_oe;

    always #(CLK_NS/2) clk = ~clk;

    i2cs_regslave uut (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (scl),
        .sda_i      (sda_bus),
        .sda_oe_o   (sda_oe),
        .pin_addr_i (pins),
        .wp_n_i     (wp_n)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s got %0h expected %0h", req, got, exp);
        end
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(posedge clk);
            while (got_q.size() > 0 && exp_q.size() > 0) begin
                logic [7:0] g, e;
                string t;
                g = got_q.pop_front();
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t, {24'h0, g}, {24'h0, e});
            end
        end
    end

    task automatic qwait();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_drv = 1'b1; qwait();
        scl = 1'b1;     qwait();
        sda_drv = 1'b0; qwait();
        scl = 1'b0;     qwait();
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; qwait();
        scl = 1'b1;     qwait();
        sda_drv = 1'b1; qwait();
    endtask

    task automatic send_bit(input logic b);
        sda_drv = b; qwait();
        scl = 1'b1;  qwait(); qwait();
        scl = 1'b0;  qwait();
    endtask

    task automatic recv_bit(output logic b);
        sda_drv = 1'b1; qwait();
        scl = 1'b1;     qwait();
        b = sda_bus;    qwait();
        scl = 1'b0;     qwait();
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic x;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(x);
        ack = ~x;
    endtask

    task automatic recv_byte(output logic [7:0] v, input logic give_ack);
        for (int i = 7; i >= 0; i--) recv_bit(v[i]);
        send_bit(~give_ack);
    endtask

    // page write of n bytes from wbuf; every byte must be acknowledged (R2/R10)
    task automatic wr_page(input logic [7:0] dev, input logic [7:0] ptr, input int n, input string tag);
        logic a;
        bus_start();
        send_byte(dev, a);  chk({tag, " R2 dev ack"}, {31'h0, a}, 1);
        send_byte(ptr, a);  chk({tag, " R2 ptr ack"}, {31'h0, a}, 1);
        for (int k = 0; k < n; k++) begin
            send_byte(wbuf[k], a);
            chk({tag, " R10 data ack"}, {31'h0, a}, 1);
        end
        bus_stop();
    endtask

    task automatic wr1(input logic [7:0] dev, input logic [7:0] ptr, input logic [7:0] d, input string tag);
        wbuf[0] = d;
        wr_page(dev, ptr, 1, tag);
    endtask

    // pointer write, repeated start, n reads; expected values pushed to scoreboard
    task automatic rd(input logic [7:0] dev, input logic [7:0] ptr, input int n,
                      input logic [7:0] e0, input logic [7:0] e1,
                      input logic [7:0] e2, input logic [7:0] e3, input string tag);
        logic a;
        logic [7:0] v;
        logic [7:0] ev[4];
        ev[0] = e0; ev[1] = e1; ev[2] = e2; ev[3] = e3;
        bus_start();
        send_byte(dev, a);          chk({tag, " R1 dev ack"}, {31'h0, a}, 1);
        send_byte(ptr, a);          chk({tag, " R2 ptr ack"}, {31'h0, a}, 1);
        bus_start();
        send_byte(dev | 8'h01, a);  chk({tag, " R4 read ack"}, {31'h0, a}, 1);
        for (int k = 0; k < n; k++) begin
            exp_q.push_back(ev[k]);
            tag_q.push_back({tag, " R4 data"});
            recv_byte(v, k < n - 1);
            got_q.push_back(v);
        end
        qwait(); qwait();
        chk({tag, " R5 released after NACK"}, {31'h0, sda_oe}, 0);
        bus_stop();
    endtask

    task automatic expect_nack(input logic [7:0] dev, input string tag);
        logic a;
        bus_start();
        send_byte(dev, a);
        chk({tag, " R1 no ack"}, {31'h0, a}, 0);
        qwait();
        chk({tag, " R1 line released"}, {31'h0, sda_oe}, 0);
        bus_stop();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        qwait();
        chk("R11 reset releases SDA", {31'h0, sda_oe}, 0);

        // R1: wrong device type, wrong strap bits
        expect_nack(8'hBA, "R1 type");
        expect_nack(8'hA8, "R1 pins");

        // R6: protection register reads zero
        rd(8'hAA, 8'h42, 1, 8'h00, 0, 0, 0, "R6 prot read");

        // R10: protected memory write acked but not stored
        wr1(8'hAA, 8'h80, 8'h11, "R10 mem locked");
        rd(8'hAA, 8'h80, 1, 8'h00, 0, 0, 0, "R10 mem unchanged");

        // R7 + R3: unlock memory, page write wraps at 0x8F
        wr1(8'hAA, 8'h42, 8'h50, "R7 mem unlock");
        for (int k = 0; k < 6; k++) wbuf[k] = 8'hD0 + 8'(k);
        wr_page(8'hAA, 8'h8C, 6, "R3 page");
        rd(8'hAA, 8'h8E, 4, 8'hD2, 8'hD3, 8'h00, 8'h00, "R4 cross page read");
        rd(8'hAA, 8'h80, 2, 8'hD4, 8'hD5, 0, 0, "R3 wrapped bytes");
        rd(8'hAA, 8'h8C, 2, 8'hD0, 8'hD1, 0, 0, "R3 first bytes");

        // R7: configuration still closed
        wr1(8'hAA, 8'h10, 8'h77, "R7 cfg locked");
        rd(8'hAA, 8'h10, 1, 8'h00, 0, 0, 0, "R7 cfg unchanged");
        wr1(8'hAA, 8'h42, 8'h55, "R7 both unlock");
        wr1(8'hAA, 8'h10, 8'h77, "R7 cfg write");
        rd(8'hAA, 8'h10, 1, 8'h77, 0, 0, 0, "R7 cfg stored");

        // R8: pin protection
        wp_n = 1'b0;
        wr1(8'hAA, 8'h11, 8'h99, "R8 cfg pin");
        wr1(8'hAA, 8'h85, 8'h44, "R8 mem pin");
        wp_n = 1'b1;
        rd(8'hAA, 8'h11, 1, 8'h00, 0, 0, 0, "R8 cfg unchanged");
        rd(8'hAA, 8'h85, 1, 8'h00, 0, 0, 0, "R8 mem unchanged");

        // R7: re-protect memory only
        wr1(8'hAA, 8'h42, 8'h05, "R7 mem relock");
        wr1(8'hAA, 8'h80, 8'hEE, "R7 mem blocked");
        rd(8'hAA, 8'h80, 1, 8'hD4, 0, 0, 0, "R7 mem kept");
        wr1(8'hAA, 8'h12, 8'h21, "R7 cfg open");
        rd(8'hAA, 8'h12, 1, 8'h21, 0, 0, 0, "R7 cfg open stored");

        // R1: change device type to 3 -> address 0x3A
        wr1(8'hAA, 8'h43, 8'h03, "R1 new type");
        expect_nack(8'hAA, "R1 old type");
        rd(8'h3A, 8'h43, 1, 8'h03, 0, 0, 0, "R1 type readback");

        // R9: lock
        wr1(8'h3A, 8'h43, 8'h83, "R9 set lock");
        rd(8'h3A, 8'h43, 1, 8'h83, 0, 0, 0, "R9 lock readback");
        wr1(8'h3A, 8'h10, 8'h12, "R9 cfg blocked");
        rd(8'h3A, 8'h10, 1, 8'h77, 0, 0, 0, "R9 cfg kept");
        wr1(8'h3A, 8'h43, 8'h03, "R9 unlock attempt");
        rd(8'h3A, 8'h43, 1, 8'h83, 0, 0, 0, "R9 lock kept");

        // R11: START in the middle of an address byte
        bus_start();
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        wr1(8'h3A, 8'h42, 8'h50, "R11 restart");
        wr1(8'h3A, 8'hFF, 8'h5A, "R4 top byte");
        rd(8'h3A, 8'hFF, 2, 8'h5A, 8'h00, 0, 0, "R4 pointer wrap");

        repeat (20) @(posedge clk);
        chk("R4 scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule